// File: doc/BRIEF.md
# Two-Channel DMA Bus Grant Arbiter

This block decides, cycle by cycle, which of three masters owns a single internal bus: the CPU or one of the DMA channels. Each channel has a request line, a mode bit that selects cycle-steal or burst operation, and a strobe that marks the last cycle of each transfer unit it moves. Channel 0 always has priority over channel 1. The CPU owns the bus whenever no DMA work is pending. Ownership changes only at the end of a transfer unit.

A cycle-steal channel gives the bus up after every unit. In most cases the CPU then gets one cycle before the next DMA unit. If a burst-mode channel is still requesting at that point, the bus goes directly to that burst channel instead. A cycle-steal channel 0 and a burst channel 1 therefore alternate unit by unit with no CPU cycles between them. Once channel 0 stops requesting, channel 1 finishes its burst. The CPU gets the bus back only after every competing burst request has cleared.

Priority rotation is not implemented. A separate input reports that the surrounding system runs its channels in round-robin order. When that input is set and the two channels are in different modes, the block raises an error flag, because that combination is unsupported.

Top module: `dma_bus_arbiter`

## Requirements
- R1: A synchronous active-high reset leaves the grant on the CPU (grant = 3'b001) with bus_held low.
- R2: The registered grant is always one-hot. Bit 0 is the CPU, bit 1 is channel 0 and bit 2 is channel 1.
- R3: A channel that holds the grant keeps it until its own unit_done bit is high. A unit_done bit of a channel that does not hold the grant has no effect.
- R4: While the CPU holds the grant, the next cycle's grant goes to the lowest-numbered requesting channel. With no request pending, the grant stays on the CPU.
- R5: At the end of a unit of a cycle-steal channel (burst_mode bit = 0), if no burst channel is requesting, the grant returns to the CPU for at least one cycle.
- R6: At the end of a unit of a cycle-steal channel, if any burst channel (burst_mode bit = 1) is requesting, the grant moves directly to the lowest-numbered such channel without a CPU cycle.
- R7: At the end of a unit of a burst channel, the grant goes to the lowest-numbered requesting channel, which may be the same channel. A channel 0 request therefore interleaves with a channel 1 burst.
- R8: A burst channel whose request is low at the end of its unit releases the grant. The grant goes to the CPU if nothing else is requesting.
- R9: bus_held is high exactly when a DMA channel holds the grant.
- R10: mix_err is high exactly when rr_mode is high and the two channels' burst_mode bits differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_CH | Per-channel transfer request |
| burst_mode | input | NUM_CH | Per-channel mode, 1 = burst, 0 = cycle-steal |
| unit_done | input | NUM_CH | Per-channel strobe on the last cycle of a transfer unit |
| rr_mode | input | 1 | System runs channels in round-robin order |
| grant | output | NUM_CH+1 | One-hot registered grant, bit 0 CPU, bit i+1 channel i |
| bus_held | output | 1 | A DMA channel holds the bus |
| mix_err | output | 1 | Unsupported mix of modes under round-robin |

## Verification
Two decisions can fall due in the same cycle. The first is the end of a unit of the owning channel. The second is a change of the request picture that sets where the bus goes next, for example channel 0's request rising or a burst request falling on the very edge where a unit ends. The bench provokes these collisions with directed sequences and with random request, mode and strobe patterns. A bench-side model computes the next owner from the rules, and each cycle's grant is compared against it, tagged with the rule that applied.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int unsigned MAX_CH = 8;

  // one-hot of the lowest set bit (lowest index = highest priority)
  function automatic logic [MAX_CH-1:0] first_set(input logic [MAX_CH-1:0] v);
    logic [MAX_CH-1:0] r;
    r = '0;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (v[i]) r = '0;
      if (v[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/dma_arb_sel.sv
module dma_arb_sel #(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned GW = NUM_CH + 1
) (
  input  logic [GW-1:0]     owner,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] burst_mode,
  input  logic [NUM_CH-1:0] unit_done,
  output logic [GW-1:0]     nxt,
  output logic              unit_end,
  output logic              cs_release,
  output logic              burst_pending
);
  import dma_arb_pkg::*;

  logic [NUM_CH-1:0] ch_own;
  logic [NUM_CH-1:0] burst_req;
  logic [MAX_CH-1:0] pick_any, pick_burst;
  logic              cur_burst;

  assign ch_own        = owner[GW-1:1];
  assign burst_req     = req & burst_mode;
  assign unit_end      = |(ch_own & unit_done);
  assign cur_burst     = |(ch_own & burst_mode);
  assign cs_release    = unit_end & ~cur_burst;
  assign burst_pending = |burst_req;
  assign pick_any      = first_set(MAX_CH'(req));
  assign pick_burst    = first_set(MAX_CH'(burst_req));

  always_comb begin
    nxt = owner;
    if (owner[0] || (unit_end && cur_burst)) begin
      if (|req) nxt = {pick_any[NUM_CH-1:0], 1'b0};
      else      nxt = GW'(1);
    end else if (cs_release) begin
      if (burst_pending) nxt = {pick_burst[NUM_CH-1:0], 1'b0};
      else               nxt = GW'(1);
    end
  end

endmodule

// File: rtl/dma_arb_owner.sv
module dma_arb_owner #(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned GW = NUM_CH + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] nxt,
  output logic [GW-1:0] owner
);
  always_ff @(posedge clk) begin
    if (rst) owner <= GW'(1);
    else     owner <= nxt;
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(owner) == 1);
endmodule

// File: rtl/dma_arb_mix.sv
module dma_arb_mix #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] burst_mode,
  input  logic              rr_mode,
  output logic              mix_err
);
  // modes mixed when neither all burst nor all cycle-steal
  assign mix_err = rr_mode & ~(&burst_mode) & (|burst_mode);
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned GW = NUM_CH + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] burst_mode,
  input  logic [NUM_CH-1:0] unit_done,
  input  logic              rr_mode,
  output logic [GW-1:0]     grant,
  output logic              bus_held,
  output logic              mix_err
);
  logic [GW-1:0] nxt;
  logic          unit_end, cs_release, burst_pending;

  dma_arb_sel #(.NUM_CH(NUM_CH)) u_sel (
    .owner(grant), .req(req), .burst_mode(burst_mode), .unit_done(unit_done),
    .nxt(nxt), .unit_end(unit_end), .cs_release(cs_release),
    .burst_pending(burst_pending)
  );

  dma_arb_owner #(.NUM_CH(NUM_CH)) u_owner (
    .clk(clk), .rst(rst), .nxt(nxt), .owner(grant)
  );

  dma_arb_mix #(.NUM_CH(NUM_CH)) u_mix (
    .burst_mode(burst_mode), .rr_mode(rr_mode), .mix_err(mix_err)
  );

  assign bus_held = ~grant[0];

  // R3
  dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_held && !unit_end) |=> $stable(grant));

  // R4
  cpu_pick_ch0_chk: assert property (@(posedge clk) disable iff (rst)
    (grant[0] && req[0]) |=> grant[1]);

  // R5
  cs_to_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_release && !burst_pending) |=> grant[0]);

  // R6
  cs_to_burst_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_release && burst_pending) |=> bus_held);

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (unit_end && req == '0) |=> grant[0]);
endmodule

// File: tb/test_dma_bus_arbiter.sv
module test_dma_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] req, bm, ud;
  logic       rr;
  logic [2:0] grant;
  logic       bus_held, mix_err;

  int vectors = 0;
  int fails = 0;
  int exp_own = 0;           // 0 cpu, 1 ch0, 2 ch1
  string rule = "R1";

  always #5 clk = ~clk;

  dma_bus_arbiter i_dma_bus_arbiter (
    .clk(clk), .rst(rst), .req(req), .burst_mode(bm), .unit_done(ud),
    .rr_mode(rr), .grant(grant), .bus_held(bus_held), .mix_err(mix_err)
  );

  function automatic int lowest(input logic [1:0] v);
    if (v[0]) return 1;
    if (v[1]) return 2;
    return 0;
  endfunction

  function automatic logic [2:0] enc(input int own);
    return 3'b001 << own;
  endfunction

  // model step, written per owner case
  task automatic model_step();
    if (rst) begin exp_own = 0; rule = "R1"; return; end
    case (exp_own)
      0: begin exp_own = lowest(req); rule = "R4"; end
      default: begin
        if (!ud[exp_own-1]) rule = "R3";
        else if (bm[exp_own-1]) begin
          exp_own = lowest(req);
          rule = req[exp_own == 0 ? 0 : exp_own-1] ? "R7" : "R8";
          if (exp_own == 0) rule = "R8";
        end else begin
          exp_own = lowest(req & bm);
          rule = (exp_own == 0) ? "R5" : "R6";
        end
      end
    endcase
  endtask

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, expv);
    end
  endtask

  task automatic apply(input logic r, input logic [1:0] q, input logic [1:0] b,
                       input logic [1:0] u, input logic m);
    @(negedge clk);
    rst = r; req = q; bm = b; ud = u; rr = m;
    #1;
    check("R10", {2'b0, mix_err}, {2'b0, m & (b[0] ^ b[1])});
    @(posedge clk);
    model_step();
    #1;
    check(rule, grant, enc(exp_own));
    check("R2", {2'b0, $countones(grant) == 1}, 3'b001);
    check("R9", {2'b0, bus_held}, {2'b0, exp_own != 0});
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; req = 0; bm = 0; ud = 0; rr = 0;
    apply(1, 2'b00, 2'b00, 2'b00, 0);
    apply(1, 2'b00, 2'b00, 2'b00, 0);
    check("R1", grant, 3'b001);
    // idle: CPU stays (R4)
    apply(0, 2'b00, 2'b00, 2'b00, 0);
    // interleave: ch0 cycle-steal, ch1 burst (R6, R7)
    apply(0, 2'b10, 2'b10, 2'b00, 0);   // -> ch1
    apply(0, 2'b11, 2'b10, 2'b01, 0);   // ch0 done ignored (R3), ch1 holds
    check("R3", grant, 3'b100);
    apply(0, 2'b11, 2'b10, 2'b10, 0);   // ch1 unit end -> ch0 (R7)
    check("R7", grant, 3'b010);
    apply(0, 2'b11, 2'b10, 2'b01, 0);   // ch0 cs end -> ch1 directly (R6)
    check("R6", grant, 3'b100);
    apply(0, 2'b10, 2'b10, 2'b10, 0);   // ch0 gone, ch1 continues
    check("R7", grant, 3'b100);
    apply(0, 2'b00, 2'b10, 2'b10, 0);   // burst request dropped -> CPU (R8)
    check("R8", grant, 3'b001);
    // both cycle-steal: CPU cycle between units (R5)
    apply(0, 2'b01, 2'b00, 2'b00, 0);
    apply(0, 2'b01, 2'b00, 2'b01, 0);
    check("R5", grant, 3'b001);
    apply(0, 2'b01, 2'b00, 2'b00, 1);   // mix flag off, modes equal (R10)
    apply(0, 2'b00, 2'b01, 2'b00, 1);   // mix flag on (R10)
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] q, u;
      if (($urandom % 40) == 0) bm = 2'($urandom);
      q = 2'($urandom) | (($urandom % 3) == 0 ? 2'b00 : req);
      u = 2'($urandom % 4);
      apply(($urandom % 500) == 0, q, bm, u, ($urandom % 4) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule